// File: doc/BRIEF.md
# Variable-Block-Size Integer Motion Search Engine

This block performs an exhaustive integer-pel block-matching search for one 16x16 current macroblock inside a 31x31 reference window. The window covers every candidate displacement from -8 to +7 in both directions, which gives 256 candidates. The pixels of both images are written once into on-chip storage through two ready/valid write ports. A start pulse then runs the whole search from that storage, with no further input traffic.

A single 4x4 array of absolute-difference elements is shared in time. It evaluates the sixteen 4x4 sub-blocks of a candidate one per cycle. After the sixteenth sub-block, a merge stage adds the stored 4x4 sums into the costs of the larger partitions, 41 in all. A tracker keeps the lowest cost and its motion vector separately for each partition. A one-cycle done pulse marks the point where all 41 minima are final. The results stay on the outputs until the next search starts to update them.

Top module: `vbs_sad_search`

## Requirements
- R1: While reset is high and after it is released, done is 0, both load ports are ready, and every partition cost and vector component reads 0.
- R2: The load ports show ready only while no search is running. Each accepted beat writes the next position in row-major order: 256 positions for the current block and 961 for the window (row y, column x at index y*31+x). After the last position, writing wraps to position 0.
- R3: Partition indices 0..15 are the 4x4 sub-blocks in raster order (index = 4*row + column). Each reports the minimum over all 256 candidates of the sum of absolute differences between its 16 current pixels and the displaced window pixels. That sum ranges from 0 to 4080.
- R4: Larger partitions are reported as follows. Indices 16..23 are 8-wide by 4-tall, at 2*row + column. Indices 24..31 are 4-wide by 8-tall, at 4*row + column. Indices 32..35 are 8x8, at 2*row + column. Indices 36..37 are the upper and lower 16-wide by 8-tall halves. Indices 38..39 are the left and right 8-wide by 16-tall halves. Index 40 is the whole 16x16 block, with a cost up to 65280. Each has its own independent minimum and vector.
- R5: Candidates are scanned with the vertical offset as the outer loop and the horizontal offset as the inner loop, both rising from -8. When costs are equal, the earlier candidate is kept.
- R6: The vector components are 5-bit two's complement in -8..+7. For offset (dx, dy), current pixel (r, c) is compared with window pixel (r+dy+8, c+dx+8).
- R7: done is high for exactly one cycle. It rises on the 4352nd rising edge after the edge that samples start, and the reported minima are final in that cycle.
- R8: A start pulse during a running search has no effect on its results or on its completion time.
- R9: Stored pixels are kept between searches, so a new start without reloading gives the same results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when idle |
| cur_valid | input | 1 | Current-block pixel beat valid |
| cur_ready | output | 1 | Current-block port can accept |
| cur_data | input | 8 | Current-block pixel |
| win_valid | input | 1 | Window pixel beat valid |
| win_ready | output | 1 | Window port can accept |
| win_data | input | 8 | Window pixel |
| done | output | 1 | One-cycle search-complete pulse |
| best_cost | output | 41x16 | Minimum cost per partition |
| best_mvx | output | 41x5 | Horizontal vector per partition |
| best_mvy | output | 41x5 | Vertical vector per partition |

## Verification
The hardest behaviour to reach from the ports is the tie rule. It only shows when several candidates give exactly the same cost for a partition, and natural pixel data almost never produces that. The stimulus forces ties on purpose in three ways: flat images, an all-maximum difference image, and a window whose rows are constant. With constant rows, every horizontal offset at the planted vertical offset gives zero cost. A bench-side exhaustive model computes all 41 minima directly from pixel rectangles. It also checks that a stray start pulse injected mid-search changes neither the latency nor the results.

// File: rtl/sad_pkg.sv
package sad_pkg;
    localparam int PIX_W       = 8;
    localparam int MB_DIM      = 16;
    localparam int SUB_DIM     = 4;
    localparam int SRCH_R      = 8;

    localparam int SUB_PER_ROW = MB_DIM / SUB_DIM;
    localparam int NUM_SUB     = SUB_PER_ROW * SUB_PER_ROW;
    localparam int PE_N        = SUB_DIM * SUB_DIM;
    localparam int WIN_DIM     = MB_DIM + 2 * SRCH_R - 1;
    localparam int CUR_PIX     = MB_DIM * MB_DIM;
    localparam int WIN_PIX     = WIN_DIM * WIN_DIM;
    localparam int CUR_AW      = $clog2(CUR_PIX);
    localparam int WIN_AW      = $clog2(WIN_PIX);
    localparam int OFF_W       = $clog2(2 * SRCH_R);
    localparam int NUM_CAND    = (2 * SRCH_R) * (2 * SRCH_R);
    localparam int CAND_W      = 2 * OFF_W;
    localparam int MV_W        = OFF_W + 1;
    localparam int SUB_IDX_W   = $clog2(NUM_SUB);
    localparam int SUBX_W      = $clog2(SUB_PER_ROW);
    localparam int SAD4_W      = PIX_W + $clog2(PE_N);
    localparam int COST_W      = SAD4_W + $clog2(NUM_SUB);
    localparam int SUB_MAX     = PE_N * ((1 << PIX_W) - 1);

    // partition index layout
    localparam int P_8X4   = NUM_SUB;
    localparam int P_4X8   = P_8X4 + 8;
    localparam int P_8X8   = P_4X8 + 8;
    localparam int P_16X8  = P_8X8 + 4;
    localparam int P_8X16  = P_16X8 + 2;
    localparam int P_16X16 = P_8X16 + 2;
    localparam int NUM_PART = P_16X16 + 1;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic [SAD4_W-1:0]        sad4_t;
    typedef logic [COST_W-1:0]        cost_t;
    typedef logic signed [MV_W-1:0]   mv_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_MERGE
    } state_e;

    typedef struct packed {
        logic [OFF_W-1:0] dy;
        logic [OFF_W-1:0] dx;
    } cand_t;

    typedef struct packed {
        cost_t cost;
        mv_t   mvx;
        mv_t   mvy;
    } best_t;

    function automatic mv_t off_to_mv(input logic [OFF_W-1:0] off);
        return mv_t'({1'b0, off}) - mv_t'(SRCH_R);
    endfunction
endpackage

// File: rtl/sad_pe_array.sv
module sad_pe_array import sad_pkg::*; (
    input  pix_t [PE_N-1:0] cur_blk,
    input  pix_t [PE_N-1:0] ref_blk,
    output sad4_t           sad
);
    localparam int ROW_W = PIX_W + $clog2(SUB_DIM);

    pix_t [PE_N-1:0] absd;
    logic [SUB_DIM-1:0][ROW_W-1:0] row_sum;

    for (genvar g = 0; g < PE_N; g++) begin : g_pe
        assign absd[g] = (cur_blk[g] >= ref_blk[g]) ? (cur_blk[g] - ref_blk[g])
                                                    : (ref_blk[g] - cur_blk[g]);
    end

    for (genvar r = 0; r < SUB_DIM; r++) begin : g_row
        always_comb begin
            row_sum[r] = '0;
            for (int c = 0; c < SUB_DIM; c++) begin
                row_sum[r] = row_sum[r] + ROW_W'(absd[r * SUB_DIM + c]);
            end
        end
    end

    always_comb begin
        sad = '0;
        for (int r = 0; r < SUB_DIM; r++) begin
            sad = sad + SAD4_W'(row_sum[r]);
        end
    end
endmodule

// File: rtl/sad_merge.sv
module sad_merge import sad_pkg::*; (
    input  sad4_t [NUM_SUB-1:0]  sub_sad,
    output cost_t [NUM_PART-1:0] part_cost
);
    cost_t [3:0] quad;

    always_comb begin
        for (int i = 0; i < NUM_SUB; i++) begin
            part_cost[i] = cost_t'(sub_sad[i]);
        end
        // 8 wide, 4 tall
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 2; c++) begin
                part_cost[P_8X4 + r * 2 + c] = cost_t'(sub_sad[r * 4 + 2 * c])
                                             + cost_t'(sub_sad[r * 4 + 2 * c + 1]);
            end
        end
        // 4 wide, 8 tall
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 4; c++) begin
                part_cost[P_4X8 + r * 4 + c] = cost_t'(sub_sad[(2 * r) * 4 + c])
                                             + cost_t'(sub_sad[(2 * r + 1) * 4 + c]);
            end
        end
        // 8x8 quadrants built from the 8-wide pairs
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 2; c++) begin
                quad[r * 2 + c] = part_cost[P_8X4 + (2 * r) * 2 + c]
                                + part_cost[P_8X4 + (2 * r + 1) * 2 + c];
                part_cost[P_8X8 + r * 2 + c] = quad[r * 2 + c];
            end
        end
        for (int h = 0; h < 2; h++) begin
            part_cost[P_16X8 + h] = quad[h * 2] + quad[h * 2 + 1];
            part_cost[P_8X16 + h] = quad[h] + quad[2 + h];
        end
        part_cost[P_16X16] = quad[0] + quad[1] + quad[2] + quad[3];
    end
endmodule

// File: rtl/sad_best_track.sv
module sad_best_track import sad_pkg::*; (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic                 first,
    input  cost_t [NUM_PART-1:0] cand_cost,
    input  mv_t                  cand_mvx,
    input  mv_t                  cand_mvy,
    output best_t [NUM_PART-1:0] best
);
    always_ff @(posedge clk) begin
        if (rst) begin
            best <= '0;
        end else if (upd) begin
            for (int p = 0; p < NUM_PART; p++) begin
                // strict compare keeps the earliest candidate on ties
                if (first || (cand_cost[p] < best[p].cost)) begin
                    best[p].cost <= cand_cost[p];
                    best[p].mvx  <= cand_mvx;
                    best[p].mvy  <= cand_mvy;
                end
            end
        end
    end
endmodule

// File: rtl/vbs_sad_search.sv
module vbs_sad_search import sad_pkg::*; (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  logic                             cur_valid,
    output logic                             cur_ready,
    input  logic [PIX_W-1:0]                 cur_data,
    input  logic                             win_valid,
    output logic                             win_ready,
    input  logic [PIX_W-1:0]                 win_data,
    output logic                             done,
    output logic [NUM_PART-1:0][COST_W-1:0]  best_cost,
    output logic [NUM_PART-1:0][MV_W-1:0]    best_mvx,
    output logic [NUM_PART-1:0][MV_W-1:0]    best_mvy
);
    state_e                 state_q;
    cand_t                  cand_q;
    logic [SUB_IDX_W-1:0]   blk_q;
    logic                   first_q;
    sad4_t [NUM_SUB-1:0]    sad_file;

    pix_t                   cur_mem [CUR_PIX];
    pix_t                   win_mem [WIN_PIX];
    logic [CUR_AW-1:0]      cur_wp;
    logic [WIN_AW-1:0]      win_wp;

    pix_t [PE_N-1:0]        cur_blk;
    pix_t [PE_N-1:0]        win_blk;
    sad4_t                  pe_sad;
    cost_t [NUM_PART-1:0]   part_cost;
    best_t [NUM_PART-1:0]   best_q;

    logic [SUBX_W-1:0]            sub_x;
    logic [SUB_IDX_W-SUBX_W-1:0]  sub_y;

    assign cur_ready = (state_q == ST_IDLE);
    assign win_ready = (state_q == ST_IDLE);
    assign sub_x     = blk_q[SUBX_W-1:0];
    assign sub_y     = blk_q[SUB_IDX_W-1:SUBX_W];

    // ---------------- pixel storage ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_wp <= '0;
            win_wp <= '0;
        end else begin
            if (cur_valid && cur_ready) begin
                cur_wp <= (cur_wp == CUR_AW'(CUR_PIX - 1)) ? '0 : cur_wp + 1'b1;
            end
            if (win_valid && win_ready) begin
                win_wp <= (win_wp == WIN_AW'(WIN_PIX - 1)) ? '0 : win_wp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (cur_valid && cur_ready) cur_mem[cur_wp] <= cur_data;
        if (win_valid && win_ready) win_mem[win_wp] <= win_data;
    end

    // ---------------- operand fetch for the PE array ----------------
    for (genvar gi = 0; gi < PE_N; gi++) begin : g_fetch
        localparam int RI = gi / SUB_DIM;
        localparam int CI = gi % SUB_DIM;
        logic [CUR_AW-1:0] c_idx;
        logic [WIN_AW-1:0] w_idx;
        always_comb begin
            c_idx = CUR_AW'((int'(sub_y) * SUB_DIM + RI) * MB_DIM
                            + int'(sub_x) * SUB_DIM + CI);
            w_idx = WIN_AW'((int'(cand_q.dy) + int'(sub_y) * SUB_DIM + RI) * WIN_DIM
                            + int'(cand_q.dx) + int'(sub_x) * SUB_DIM + CI);
        end
        assign cur_blk[gi] = cur_mem[c_idx];
        assign win_blk[gi] = win_mem[w_idx];
    end

    sad_pe_array u_pe (
        .cur_blk (cur_blk),
        .ref_blk (win_blk),
        .sad     (pe_sad)
    );

    sad_merge u_merge (
        .sub_sad   (sad_file),
        .part_cost (part_cost)
    );

    sad_best_track u_best (
        .clk       (clk),
        .rst       (rst),
        .upd       (state_q == ST_MERGE),
        .first     (first_q),
        .cand_cost (part_cost),
        .cand_mvx  (off_to_mv(cand_q.dx)),
        .cand_mvy  (off_to_mv(cand_q.dy)),
        .best      (best_q)
    );

    // ---------------- search sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cand_q   <= '0;
            blk_q    <= '0;
            first_q  <= 1'b0;
            done     <= 1'b0;
            sad_file <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cand_q  <= '0;
                        blk_q   <= '0;
                        first_q <= 1'b1;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    sad_file[blk_q] <= pe_sad;
                    blk_q           <= blk_q + 1'b1;
                    if (blk_q == SUB_IDX_W'(NUM_SUB - 1)) state_q <= ST_MERGE;
                end
                ST_MERGE: begin
                    first_q <= 1'b0;
                    if (cand_q == cand_t'(CAND_W'(NUM_CAND - 1))) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        cand_q  <= cand_t'(cand_q + 1'b1);
                        state_q <= ST_EVAL;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PART; p++) begin
            best_cost[p] = best_q[p].cost;
            best_mvx[p]  = best_q[p].mvx;
            best_mvy[p]  = best_q[p].mvy;
        end
    end
endmodule

// File: rtl/sad_search_chk.sv
module sad_search_chk import sad_pkg::*; (
    input logic                             clk,
    input logic                             rst,
    input logic                             start,
    input logic                             cur_ready,
    input logic                             win_ready,
    input logic                             done,
    input logic [NUM_PART-1:0][COST_W-1:0]  best_cost,
    input logic [NUM_PART-1:0][MV_W-1:0]    best_mvx,
    input logic [NUM_PART-1:0][MV_W-1:0]    best_mvy
);
    localparam int SUM_W = COST_W + 4;

    logic [SUM_W-1:0] sub_sum;
    logic             sub_ok;
    logic             mv_ok;

    always_comb begin
        sub_sum = '0;
        sub_ok  = 1'b1;
        for (int i = 0; i < NUM_SUB; i++) begin
            sub_sum = sub_sum + SUM_W'(best_cost[i]);
            if (best_cost[i] > COST_W'(SUB_MAX)) sub_ok = 1'b0;
        end
        mv_ok = 1'b1;
        for (int p = 0; p < NUM_PART; p++) begin
            if (best_mvx[p][MV_W-1] != best_mvx[p][MV_W-2]) mv_ok = 1'b0;
            if (best_mvy[p][MV_W-1] != best_mvy[p][MV_W-2]) mv_ok = 1'b0;
        end
    end

    // R2: accepting a start closes both load ports
    assert_load_closed_R2: assert property (@(posedge clk) disable iff (rst)
        (start && cur_ready) |=> (!cur_ready && !win_ready));

    // R7: completion pulse lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: completion only ends a running search
    assert_done_from_busy_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(!cur_ready));

    // R3: sub-block minima stay within the 16-pixel range
    assert_sub_range_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> sub_ok);

    // R4: whole-block minimum cannot beat the sum of independent sub minima
    assert_merge_bound_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (SUM_W'(best_cost[P_16X16]) >= sub_sum));

    // R6: every vector component lies in -8..+7
    assert_mv_range_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> mv_ok);
endmodule

bind vbs_sad_search sad_search_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cur_ready (cur_ready),
    .win_ready (win_ready),
    .done      (done),
    .best_cost (best_cost),
    .best_mvx  (best_mvx),
    .best_mvy  (best_mvy)
);

// File: tb/sim_vbs_sad_search.sv
module sim_vbs_sad_search;
    import sad_pkg::*;

    localparam int LAT = NUM_CAND * (NUM_SUB + 1);
    localparam int NV  = 8;
    // wmode, seed, cmode, cval, dy, dx, exp_mvx, exp_mvy, exp_cost16x16
    localparam int TBL [NV][9] = '{
        '{0, 1,   0, 0,   -8, -8, -8, -8, 0},
        '{0, 2,   0, 0,    7,  7,  7,  7, 0},
        '{0, 3,   0, 0,    0,  0,  0,  0, 0},
        '{0, 4,   0, 0,   -3,  5,  5, -3, 0},
        '{0, 5,   0, 0,    6, -8, -8,  6, 0},
        '{1, 128, 1, 128,  0,  0, -8, -8, 0},
        '{1, 0,   1, 255,  0,  0, -8, -8, 65280},
        '{2, 9,   0, 0,    2,  3, -8,  2, 0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cur_valid = 1'b0;
    logic win_valid = 1'b0;
    logic [PIX_W-1:0] cur_data = '0;
    logic [PIX_W-1:0] win_data = '0;
    logic cur_ready, win_ready, done;
    logic [NUM_PART-1:0][COST_W-1:0] best_cost;
    logic [NUM_PART-1:0][MV_W-1:0]   best_mvx;
    logic [NUM_PART-1:0][MV_W-1:0]   best_mvy;

    int n_tests = 0;
    int n_fail  = 0;
    int wimg [WIN_DIM][WIN_DIM];
    int cimg [MB_DIM][MB_DIM];
    int exp_cost [NUM_PART];
    int exp_mvx  [NUM_PART];
    int exp_mvy  [NUM_PART];

    always #2 clk = ~clk;

    vbs_sad_search u0 (
        .clk(clk), .rst(rst), .start(start),
        .cur_valid(cur_valid), .cur_ready(cur_ready), .cur_data(cur_data),
        .win_valid(win_valid), .win_ready(win_ready), .win_data(win_data),
        .done(done), .best_cost(best_cost), .best_mvx(best_mvx), .best_mvy(best_mvy)
    );

    initial begin
        repeat (195000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int win_pix(input int mode, input int seed, input int y, input int x);
        logic [31:0] h;
        if (mode == 1) return seed;
        if (mode == 2) return y * 7 + seed;
        h = (32'(x) * 32'd131 + 32'(y) * 32'd31 + 32'(seed) * 32'd1009) * 32'h9E3779B1;
        return int'(h[23:16]);
    endfunction

    function automatic void part_rect(input int p, output int x0, output int y0,
                                      output int w, output int h);
        int q;
        if (p < 16)      begin x0 = (p % 4) * 4; y0 = (p / 4) * 4; w = 4; h = 4; end
        else if (p < 24) begin q = p - 16; x0 = (q % 2) * 8; y0 = (q / 2) * 4; w = 8; h = 4; end
        else if (p < 32) begin q = p - 24; x0 = (q % 4) * 4; y0 = (q / 4) * 8; w = 4; h = 8; end
        else if (p < 36) begin q = p - 32; x0 = (q % 2) * 8; y0 = (q / 2) * 8; w = 8; h = 8; end
        else if (p < 38) begin q = p - 36; x0 = 0; y0 = q * 8; w = 16; h = 8; end
        else if (p < 40) begin q = p - 38; x0 = q * 8; y0 = 0; w = 8; h = 16; end
        else begin x0 = 0; y0 = 0; w = 16; h = 16; end
    endfunction

    task automatic build_images(input int wm, input int seed, input int cm,
                                input int cval, input int dy, input int dx);
        for (int y = 0; y < WIN_DIM; y++)
            for (int x = 0; x < WIN_DIM; x++)
                wimg[y][x] = win_pix(wm, seed, y, x);
        for (int r = 0; r < MB_DIM; r++)
            for (int c = 0; c < MB_DIM; c++)
                cimg[r][c] = (cm == 1) ? cval : wimg[r + dy + 8][c + dx + 8];
    endtask

    task automatic compute_model();
        int ad [MB_DIM][MB_DIM];
        int x0, y0, w, h, s;
        bit first = 1'b1;
        for (int oy = 0; oy < 16; oy++) begin
            for (int ox = 0; ox < 16; ox++) begin
                for (int r = 0; r < MB_DIM; r++)
                    for (int c = 0; c < MB_DIM; c++) begin
                        s = cimg[r][c] - wimg[r + oy][c + ox];
                        ad[r][c] = (s < 0) ? -s : s;
                    end
                for (int p = 0; p < NUM_PART; p++) begin
                    part_rect(p, x0, y0, w, h);
                    s = 0;
                    for (int r = y0; r < y0 + h; r++)
                        for (int c = x0; c < x0 + w; c++)
                            s += ad[r][c];
                    if (first || s < exp_cost[p]) begin
                        exp_cost[p] = s;
                        exp_mvx[p]  = ox - 8;
                        exp_mvy[p]  = oy - 8;
                    end
                end
                first = 1'b0;
            end
        end
    endtask

    task automatic load_images();
        for (int i = 0; i < WIN_PIX; i++) begin
            @(negedge clk);
            win_valid = 1'b1;
            win_data  = PIX_W'(wimg[i / WIN_DIM][i % WIN_DIM]);
        end
        @(negedge clk);
        win_valid = 1'b0;
        for (int i = 0; i < CUR_PIX; i++) begin
            cur_valid = 1'b1;
            cur_data  = PIX_W'(cimg[i / MB_DIM][i % MB_DIM]);
            @(negedge clk);
        end
        cur_valid = 1'b0;
    endtask

    // returns edges from the start edge to the first cycle done is seen
    task automatic run_search(input int poke_at, output int lat);
        int n = 0;
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 50)
                check(!cur_ready && !win_ready, "R2", "ports closed mid-search",
                      int'(cur_ready) + int'(win_ready), 0);
            if (poke_at != 0 && n == poke_at) start = 1'b1;
            else start = 1'b0;
            if (done || n > LAT + 100) break;
        end
        lat = n;
        @(negedge clk);
        check(!done, "R7", "done width", int'(done), 0);
    endtask

    task automatic compare_all(input string ctx);
        int bad_s = 0, bad_l = 0, fp_s = -1, fp_l = -1;
        for (int p = 0; p < NUM_PART; p++) begin
            bit ok;
            ok = (int'(best_cost[p]) == exp_cost[p])
              && (int'($signed(best_mvx[p])) == exp_mvx[p])
              && (int'($signed(best_mvy[p])) == exp_mvy[p]);
            if (!ok) begin
                if (p < NUM_SUB) begin bad_s++; if (fp_s < 0) fp_s = p; end
                else begin bad_l++; if (fp_l < 0) fp_l = p; end
            end
        end
        if (fp_s >= 0)
            $display("  %s sub-block %0d: cost %0d mv (%0d,%0d) model %0d (%0d,%0d)", ctx, fp_s,
                     best_cost[fp_s], $signed(best_mvx[fp_s]), $signed(best_mvy[fp_s]),
                     exp_cost[fp_s], exp_mvx[fp_s], exp_mvy[fp_s]);
        if (fp_l >= 0)
            $display("  %s partition %0d: cost %0d mv (%0d,%0d) model %0d (%0d,%0d)", ctx, fp_l,
                     best_cost[fp_l], $signed(best_mvx[fp_l]), $signed(best_mvy[fp_l]),
                     exp_cost[fp_l], exp_mvx[fp_l], exp_mvy[fp_l]);
        check(bad_s == 0, "R3", {ctx, " 4x4 minima mismatches"}, bad_s, 0);
        check(bad_l == 0, "R4", {ctx, " merged minima mismatches"}, bad_l, 0);
    endtask

    task automatic check_table_row(input int v, input string ctx);
        int mx, my;
        mx = int'($signed(best_mvx[P_16X16]));
        my = int'($signed(best_mvy[P_16X16]));
        check(mx == TBL[v][6] && my == TBL[v][7], "R6",
              {ctx, " 16x16 vector x*100+y (tie order R5)"}, mx * 100 + my,
              TBL[v][6] * 100 + TBL[v][7]);
        check(int'(best_cost[P_16X16]) == TBL[v][8], "R4", {ctx, " 16x16 cost"},
              int'(best_cost[P_16X16]), TBL[v][8]);
    endtask

    initial begin
        int lat;
        int zero_bad;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        zero_bad = 0;
        for (int p = 0; p < NUM_PART; p++)
            if (best_cost[p] != 0 || best_mvx[p] != 0 || best_mvy[p] != 0) zero_bad++;
        check(!done && cur_ready && win_ready && zero_bad == 0, "R1", "reset outputs",
              int'(done) + 2 * int'(!cur_ready) + 4 * int'(!win_ready) + 8 * zero_bad, 0);

        // table of stimulus patterns with expected 16x16 results
        for (int v = 0; v < NV; v++) begin
            string ctx;
            ctx = $sformatf("vec%0d", v);
            build_images(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4], TBL[v][5]);
            compute_model();
            load_images();
            run_search(0, lat);
            check(lat == LAT, "R7", {ctx, " done latency"}, lat, LAT);
            compare_all(ctx);
            check_table_row(v, ctx);
        end

        // R9: second run on retained pixels (last vector, row-constant window)
        run_search(0, lat);
        check(lat == LAT, "R9", "rerun latency", lat, LAT);
        compare_all("R9 rerun");
        check_table_row(NV - 1, "R9 rerun");

        // R8: stray start pulse during a running search
        build_images(TBL[3][0], TBL[3][1], TBL[3][2], TBL[3][3], TBL[3][4], TBL[3][5]);
        compute_model();
        load_images();
        run_search(200, lat);
        check(lat == LAT, "R8", "latency with stray start", lat, LAT);
        compare_all("R8 stray start");
        check_table_row(3, "R8 stray start");
        repeat (3) @(negedge clk);
        check(cur_ready && !done, "R8", "idle after stray start",
              int'(cur_ready) * 2 + int'(done), 2);

        // R1: reset in the middle of a search
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        zero_bad = 0;
        for (int p = 0; p < NUM_PART; p++)
            if (best_cost[p] != 0 || best_mvx[p] != 0 || best_mvy[p] != 0) zero_bad++;
        check(!done && cur_ready && win_ready && zero_bad == 0, "R1", "mid-search reset",
              int'(done) + 2 * int'(!cur_ready) + 4 * int'(!win_ready) + 8 * zero_bad, 0);
        rst = 1'b0;

        // R2 + R9: reload after reset, write position back at 0
        build_images(TBL[2][0], TBL[2][1], TBL[2][2], TBL[2][3], TBL[2][4], TBL[2][5]);
        compute_model();
        load_images();
        run_search(0, lat);
        compare_all("R2 reload");
        check_table_row(2, "R2 reload");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule